// File: doc/BRIEF.md
# Four-Channel Compare Output Unit

This block watches a free-running 16-bit timer count that arrives from outside and compares it, every clock, with four programmable compare values, one per channel. When the count equals a channel's compare value, that channel's output pin is set, cleared or toggled, as its 2-bit action code selects. Action code 00 is a hold-at-level mode: the pin is driven to a programmable level bit and stays there regardless of matches. When the channel leaves that mode, the pin keeps its level until the next match changes it.

A lead-channel mode makes channels 1 to 3 use channel 0's action code, level bit and compare value, so that all four pins move together under channel 0's settings. Every match sets a sticky flag for its channel. Software clears a flag by writing 1 to it. Flags are gated by per-channel enable bits and ORed into one registered interrupt line. A simple write port and a combinational read port give access to the configuration, the compare values, the flags and the enables.

Top module: `oc_unit`

## Requirements
- R1: After reset all four pins, all flags and the interrupt output are 0.
- R2: A match occurs in a cycle where the count equals the channel's compare value. On the clock edge that samples a match, the pin changes by action code: 01 drives it to 1, 10 drives it to 0, 11 inverts it.
- R3: While a channel's action code is 00, its pin is driven to that channel's level bit (register 0, bit i for channel i) from the edge after the setting is in place.
- R4: While a channel's action code is 00, a match does not change its pin.
- R5: When a channel's action code changes from 00 to a nonzero code, the pin keeps the forced level until that channel's next match.
- R6: Each match sets that channel's flag (register 2, bit i) on the sampling edge, whatever the action code.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a clear and a match of the same channel fall in the same cycle, the flag stays set.
- R8: The interrupt output is registered: one edge after the flags change, it equals the OR over channels of flag AND enable (register 3, bit i).
- R9: With the lead bit set (register 0, bit 4), pins 1 to 3 use channel 0's action code, level bit and compare value, and their own settings have no effect.
- R10: A compare value written in a cycle applies from the next edge. The value written does not cause a match in its own write cycle.
- R11: Register map (16-bit data): 0 holds the level bits [3:0] and the lead bit [4]; 1 holds the action codes, with channel i at bits [2i+1:2i]; 2 holds the flags; 3 holds the enables; 4 to 7 hold the compare values of channels 0 to 3. Every register reads back through the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt | input | 16 | Free-running timer count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| oc_pin | output | 4 | Compare output pins |
| irq | output | 1 | Shared compare interrupt |

## Verification
Two pairs of functions can fall in the same cycle: a software flag clear together with a new match on the same channel, and a compare-value write together with a count that equals the new value. The bench drives the write strobe and the matching count on the same clock edge. For the first pair it expects the flag to stay set. For the second it expects no flag on that edge and a flag only when the count repeats the value later. The scoreboard compares the pins, the flags read through the read port, and the interrupt line after every edge.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } oc_act_e;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_ACT  = 1;
  localparam int unsigned ADR_FLAG = 2;
  localparam int unsigned ADR_EN   = 3;
  localparam int unsigned ADR_CMP0 = 4;
endpackage

// File: rtl/oc_regs.sv
module oc_regs #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [N_CH-1:0]       match,
  output logic [DATA_W-1:0]     rd_data,
  output logic [N_CH-1:0]       lvl_q,
  output logic                  lead_q,
  output logic [2*N_CH-1:0]     act_q,
  output logic [N_CH-1:0]       en_q,
  output logic [N_CH-1:0]       flag_q,
  output logic [N_CH*CNT_W-1:0] cmp_q
);
  import oc_pkg::*;

  logic ctrl_we, act_we, flag_we, en_we;
  logic [N_CH-1:0] cmp_we;
  logic [N_CH-1:0] flag_d;

  always_comb begin
    ctrl_we = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    act_we  = wr_en && (wr_addr == ADDR_W'(ADR_ACT));
    flag_we = wr_en && (wr_addr == ADDR_W'(ADR_FLAG));
    en_we   = wr_en && (wr_addr == ADDR_W'(ADR_EN));
    for (int i = 0; i < N_CH; i++) begin
      cmp_we[i] = wr_en && (wr_addr == ADDR_W'(ADR_CMP0 + i));
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (flag_we) flag_d = flag_d & ~wr_data[N_CH-1:0];
    flag_d = flag_d | match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      lead_q <= 1'b0;
      act_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (ctrl_we) begin
        lvl_q  <= wr_data[N_CH-1:0];
        lead_q <= wr_data[N_CH];
      end
      if (act_we) act_q <= wr_data[2*N_CH-1:0];
      if (en_we)  en_q  <= wr_data[N_CH-1:0];
      flag_q <= flag_d;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[g*CNT_W +: CNT_W] <= '0;
      end else if (cmp_we[g]) begin
        cmp_q[g*CNT_W +: CNT_W] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (int'(rd_addr))
      ADR_CTRL: begin
        rd_data[N_CH-1:0] = lvl_q;
        rd_data[N_CH]     = lead_q;
      end
      ADR_ACT:  rd_data[2*N_CH-1:0] = act_q;
      ADR_FLAG: rd_data[N_CH-1:0]   = flag_q;
      ADR_EN:   rd_data[N_CH-1:0]   = en_q;
      default: begin
        for (int i = 0; i < N_CH; i++) begin
          if (int'(rd_addr) == ADR_CMP0 + i) rd_data[CNT_W-1:0] = cmp_q[i*CNT_W +: CNT_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [1:0]       act,
  input  logic             lvl,
  output logic             match,
  output logic             pin
);
  import oc_pkg::*;

  logic pin_d;

  always_comb begin
    match = (cnt == cmp);
    pin_d = pin;
    case (oc_act_e'(act))
      ACT_HOLD: pin_d = lvl;
      ACT_SET:  if (match) pin_d = 1'b1;
      ACT_CLR:  if (match) pin_d = 1'b0;
      ACT_TGL:  if (match) pin_d = ~pin;
      default:  pin_d = pin;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_d;
  end
endmodule

// File: rtl/oc_irq.sv
module oc_irq #(
  parameter int unsigned N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] flag,
  input  logic [N_CH-1:0] en,
  output logic            irq
);
  logic irq_d;

  always_comb irq_d = |(flag & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/oc_unit.sv
module oc_unit #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tmr_cnt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_CH-1:0]   oc_pin,
  output logic              irq
);
  localparam int unsigned CMP_BITS = N_CH * CNT_W;

  logic [N_CH-1:0]     lvl_q, en_q, flag_q, match;
  logic                lead_q;
  logic [2*N_CH-1:0]   act_q;
  logic [CMP_BITS-1:0] cmp_q;

  oc_regs #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .match(match), .rd_data(rd_data), .lvl_q(lvl_q),
    .lead_q(lead_q), .act_q(act_q), .en_q(en_q), .flag_q(flag_q), .cmp_q(cmp_q)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [CNT_W-1:0] eff_cmp;
    logic [1:0]       eff_act;
    logic             eff_lvl;
    if (g == 0) begin : g_lead
      assign eff_cmp = cmp_q[0 +: CNT_W];
      assign eff_act = act_q[1:0];
      assign eff_lvl = lvl_q[0];
    end else begin : g_follow
      assign eff_cmp = lead_q ? cmp_q[0 +: CNT_W] : cmp_q[g*CNT_W +: CNT_W];
      assign eff_act = lead_q ? act_q[1:0]        : act_q[2*g +: 2];
      assign eff_lvl = lead_q ? lvl_q[0]          : lvl_q[g];
    end
    oc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(tmr_cnt), .cmp(eff_cmp), .act(eff_act),
      .lvl(eff_lvl), .match(match[g]), .pin(oc_pin[g])
    );
  end

  oc_irq #(.N_CH(N_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .flag(flag_q), .en(en_q), .irq(irq)
  );
endmodule

// File: rtl/oc_unit_chk.sv
module oc_unit_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CNT_W-1:0]      tmr_cnt,
  input logic [N_CH-1:0]       oc_pin,
  input logic                  irq,
  input logic [N_CH-1:0]       lvl_q,
  input logic                  lead_q,
  input logic [2*N_CH-1:0]     act_q,
  input logic [N_CH-1:0]       en_q,
  input logic [N_CH-1:0]       flag_q,
  input logic [N_CH*CNT_W-1:0] cmp_q
);
  logic hit0;
  assign hit0 = (tmr_cnt == cmp_q[0 +: CNT_W]);

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q[1:0] == 2'b11 && hit0) |=> oc_pin[0] != $past(oc_pin[0]));

  p_force_lvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q[1:0] == 2'b00) |=> oc_pin[0] == $past(lvl_q[0]));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q[1:0] != 2'b00 && !hit0) |=> $stable(oc_pin[0]));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit0 |=> flag_q[0]);

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & en_q)) |=> irq);

  p_lead_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_q && act_q[1:0] == 2'b00) |=> oc_pin == {N_CH{$past(lvl_q[0])}});
endmodule

bind oc_unit oc_unit_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .oc_pin(oc_pin), .irq(irq),
  .lvl_q(lvl_q), .lead_q(lead_q), .act_q(act_q), .en_q(en_q), .flag_q(flag_q),
  .cmp_q(cmp_q)
);

// File: tb/oc_unit_tb_top.sv
module oc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tmr_cnt;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic [3:0]  oc_pin;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    string      tag;
    logic [3:0] pin;
    logic [3:0] flg;
    logic       irq;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  oc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .oc_pin(oc_pin), .irq(irq)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic cmp1(string tag, string what, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // monitor: pops expectations after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp1(e.tag, "pins",  oc_pin,        e.pin);
        cmp1(e.tag, "flags", rd_data[3:0],  e.flg);
        cmp1(e.tag, "irq",   {3'b0, irq},   {3'b0, e.irq});
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d, logic [15:0] cnt);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tmr_cnt = cnt;
    @(posedge clk);
  endtask

  task automatic tick(logic [15:0] cnt, logic [3:0] p, logic [3:0] f, logic i, string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b0; tmr_cnt = cnt;
    e.tag = tag; e.pin = p; e.flg = f; e.irq = i;
    q.push_back(e);
    @(posedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; tmr_cnt = 16'hFFFF; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = 3'd2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    tick(16'hFFFF, 4'b0000, 4'b0000, 1'b0, "R1 reset");

    // R11 map: level bits, action codes, enables, compare values
    wr(3'd0, 16'h0008, 16'hFFFF);
    wr(3'd1, 16'h002D, 16'hFFFF);   // ch0 set, ch1 toggle, ch2 clear, ch3 hold
    wr(3'd3, 16'h0003, 16'hFFFF);
    wr(3'd4, 16'h0010, 16'hFFFF);
    wr(3'd5, 16'h0020, 16'hFFFF);
    wr(3'd6, 16'h0030, 16'hFFFF);
    wr(3'd7, 16'h0040, 16'hFFFF);
    tick(16'hFFFF, 4'b1000, 4'b0000, 1'b0, "R3 forced level");
    tick(16'h0010, 4'b1001, 4'b0001, 1'b0, "R2 set / R6 flag");
    tick(16'hFFFF, 4'b1001, 4'b0001, 1'b1, "R8 irq one edge later");
    tick(16'h0020, 4'b1011, 4'b0011, 1'b1, "R2 toggle up");
    tick(16'h0020, 4'b1001, 4'b0011, 1'b1, "R2 toggle down");
    tick(16'h0030, 4'b1001, 4'b0111, 1'b1, "R2 clear");
    tick(16'h0040, 4'b1001, 4'b1111, 1'b1, "R4 match ignored in hold / R6");

    wr(3'd2, 16'h000F, 16'hFFFF);
    tick(16'hFFFF, 4'b1001, 4'b0000, 1'b0, "R7 write-one clear");
    wr(3'd2, 16'h0001, 16'h0010);   // clear and match of ch0 together
    tick(16'hFFFF, 4'b1001, 4'b0001, 1'b1, "R7 clear vs match");

    wr(3'd1, 16'h00AD, 16'hFFFF);   // ch3 leaves hold with clear action
    tick(16'hFFFF, 4'b1001, 4'b0001, 1'b1, "R5 level kept after release");
    tick(16'h0040, 4'b0001, 4'b1001, 1'b1, "R5 next match acts");

    wr(3'd2, 16'h000F, 16'hFFFF);
    wr(3'd4, 16'h0055, 16'h0055);   // compare write while count equals new value
    tick(16'hFFFF, 4'b0001, 4'b0000, 1'b0, "R10 no match in write cycle");
    tick(16'h0055, 4'b0001, 4'b0001, 1'b0, "R10 new value applies");

    wr(3'd2, 16'h000F, 16'hFFFF);
    wr(3'd0, 16'h0010, 16'hFFFF);   // lead bit on
    tick(16'h0020, 4'b0001, 4'b0000, 1'b0, "R9 own compare ignored");
    tick(16'h0055, 4'b1111, 4'b1111, 1'b0, "R9 all follow ch0 set");
    tick(16'hFFFF, 4'b1111, 4'b1111, 1'b1, "R8 irq from flags");
    wr(3'd1, 16'h00AE, 16'hFFFF);   // ch0 action clear
    tick(16'h0055, 4'b0000, 4'b1111, 1'b1, "R9 follow current ch0 action");
    wr(3'd0, 16'h0011, 16'hFFFF);
    wr(3'd1, 16'h00AC, 16'hFFFF);   // ch0 hold, level 1
    tick(16'hFFFF, 4'b1111, 4'b1111, 1'b1, "R9 lead hold level");

    @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule